// File: doc/BRIEF.md
# ECC Write Error Injector

This block sits between the check-bit encoder of an ECC-protected RAM and the RAM's write port. It passes each encoded codeword through unchanged unless software has armed an injection. When armed, it inverts one bit of the codeword (a correctable error) or two bits (a non-correctable error). A later read of that address then raises the matching ECC event in the decoder.

Software programs the block through a 16-bit control word. The word holds four arming bits and a 7-bit bit index. Two of the arming bits are continuous: they corrupt every write until software clears them. The other two are one-shot: each clears itself after the first write it actually corrupts. Injection happens only on cycles where the write strobe is high and the single-bit reporting enable input is 1.

The corruption is combinational, so the codeword reaches the RAM in the same cycle it arrives. The control word updates on the clock edge.

Top module: `ecc_wr_injector`

## Requirements
- R1: The control word resets to 0x0000 and reads back on `ctrlRd`. Its fields are: bit index in [6:0], continuous single in [8], one-shot single in [9], continuous double in [10], one-shot double in [11]. Bits 7 and 15:12 always read 0.
- R2: A cycle with `wrStrobe` low gives `memCodeOut` equal to `wrCodeIn` in the same cycle, whatever the control word holds.
- R3: With a single-bit control armed and no double control armed, a write cycle with `corrRptEn` high inverts exactly codeword bit `index`.
- R4: With a double control armed, a write cycle with `corrRptEn` high inverts bit `index` and bit CODE_W-1. When `index` equals CODE_W-1, the second bit is CODE_W-2 instead.
- R5: When single and double controls are both armed, the double inversion of R4 is applied.
- R6: A one-shot bit clears at the clock edge that ends the write it corrupted. Only the one-shot bit of the applied kind clears. Continuous bits stay set across corrupting writes.
- R7: While `corrRptEn` is 0, no bit is inverted and the one-shot bits stay armed.
- R8: An `index` of CODE_W or more inverts no bit, and the one-shot bits stay armed.
- R9: A register write in the same cycle as a write strobe behaves as follows. The current write is corrupted by the old control word. After the edge the control word holds the written value, with no self-clear applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write enable |
| regWrData | input | 16 | Control word write data |
| corrRptEn | input | 1 | Single-bit reporting enable; injection is allowed only when this is 1 |
| wrStrobe | input | 1 | RAM write cycle strobe |
| wrCodeIn | input | CODE_W | Codeword from the check-bit encoder |
| memCodeOut | output | CODE_W | Codeword sent to the RAM, possibly corrupted |
| ctrlRd | output | 16 | Current control word |

## Verification
A wrong arming state shows up on `memCodeOut` during the very next enabled write. Depending on the fault, the output has no flip, one flip or two flips, possibly at the wrong position. A missing or misplaced self-clear appears on `ctrlRd` one edge after the corrupting write. It also shows on `memCodeOut` as an extra corruption at the following write. A wrong precedence or partner-bit choice changes the number or position of inverted bits in the same cycle as the strobe.

// File: rtl/eccinj_pkg.sv
package eccinj_pkg;
  localparam int CTRL_W = 16;
  localparam int IDX_W  = 7;

  localparam int POS_CONT_SGL = 8;
  localparam int POS_ONE_SGL  = 9;
  localparam int POS_CONT_DBL = 10;
  localparam int POS_ONE_DBL  = 11;

  localparam logic [CTRL_W-1:0] CTRL_MASK =
    CTRL_W'((1 << IDX_W) - 1) |
    (CTRL_W'(1) << POS_CONT_SGL) | (CTRL_W'(1) << POS_ONE_SGL) |
    (CTRL_W'(1) << POS_CONT_DBL) | (CTRL_W'(1) << POS_ONE_DBL);

  // strobes from the control to the datapath
  typedef struct packed {
    logic             modeSingle;
    logic             modeDouble;
    logic [IDX_W-1:0] bitIdx;
  } injStrobe_t;
endpackage

// File: rtl/eccinj_ctrl.sv
module eccinj_ctrl
  import eccinj_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              corrRptEn,
  input  logic              wrStrobe,
  input  logic              injDone,
  output injStrobe_t        strobe,
  output logic [CTRL_W-1:0] ctrlRd
);
  logic [CTRL_W-1:0] ctrlQ;
  logic armSgl, armDbl, active;

  assign armSgl = ctrlQ[POS_CONT_SGL] | ctrlQ[POS_ONE_SGL];
  assign armDbl = ctrlQ[POS_CONT_DBL] | ctrlQ[POS_ONE_DBL];
  assign active = wrStrobe & corrRptEn;

  // double takes precedence over single
  always_comb begin
    strobe.modeDouble = active & armDbl;
    strobe.modeSingle = active & armSgl & ~armDbl;
    strobe.bitIdx     = ctrlQ[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (regWrEn) begin
      ctrlQ <= regWrData & CTRL_MASK;
    end else if (injDone) begin
      if (strobe.modeDouble) ctrlQ[POS_ONE_DBL] <= 1'b0;
      else                   ctrlQ[POS_ONE_SGL] <= 1'b0;
    end
  end

  assign ctrlRd = ctrlQ;

  p_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> ctrlRd == ($past(regWrData) & CTRL_MASK));
  p_oneshot_dbl_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && injDone && strobe.modeDouble) |=> !ctrlRd[POS_ONE_DBL]);
  p_oneshot_sgl_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && injDone && strobe.modeSingle) |=> !ctrlRd[POS_ONE_SGL]);
  p_cont_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && ctrlRd[POS_CONT_SGL]) |=> ctrlRd[POS_CONT_SGL]);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !injDone) |=> $stable(ctrlRd));
endmodule

// File: rtl/eccinj_datapath.sv
module eccinj_datapath
  import eccinj_pkg::*;
#(
  parameter int CODE_W = 72
) (
  input  logic              clk,
  input  logic              rstN,
  input  injStrobe_t        strobe,
  input  logic [CODE_W-1:0] wrCodeIn,
  output logic [CODE_W-1:0] memCodeOut,
  output logic              injDone
);
  localparam int PAIR_MAIN = CODE_W - 1;
  localparam int PAIR_ALT  = CODE_W - 2;

  logic              inRange;
  logic [IDX_W-1:0]  pairIdx;
  logic [CODE_W-1:0] flipMask;

  assign inRange = (int'(strobe.bitIdx) < CODE_W);
  assign pairIdx = (strobe.bitIdx == IDX_W'(PAIR_MAIN)) ? IDX_W'(PAIR_ALT)
                                                        : IDX_W'(PAIR_MAIN);

  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    assign flipMask[i] = inRange &&
      (((strobe.modeSingle || strobe.modeDouble) && strobe.bitIdx == IDX_W'(i)) ||
       (strobe.modeDouble && pairIdx == IDX_W'(i)));
  end

  assign memCodeOut = wrCodeIn ^ flipMask;
  assign injDone    = |flipMask;

  p_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.modeSingle && !strobe.modeDouble) |-> memCodeOut == wrCodeIn);
  p_single_weight_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.modeSingle && inRange) |-> $countones(memCodeOut ^ wrCodeIn) == 1);
  p_double_weight_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.modeDouble && inRange) |-> $countones(memCodeOut ^ wrCodeIn) == 2);
  p_double_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.modeDouble && inRange) |-> memCodeOut[pairIdx] != wrCodeIn[pairIdx]);
  p_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> (memCodeOut == wrCodeIn && !injDone));
endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
  import eccinj_pkg::*;
#(
  parameter int CODE_W = 72
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  input  logic              corrRptEn,
  input  logic              wrStrobe,
  input  logic [CODE_W-1:0] wrCodeIn,
  output logic [CODE_W-1:0] memCodeOut,
  output logic [15:0]       ctrlRd
);
  injStrobe_t strobe;
  logic       injDone;

  eccinj_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .corrRptEn (corrRptEn),
    .wrStrobe  (wrStrobe),
    .injDone   (injDone),
    .strobe    (strobe),
    .ctrlRd    (ctrlRd)
  );

  eccinj_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrCodeIn   (wrCodeIn),
    .memCodeOut (memCodeOut),
    .injDone    (injDone)
  );
endmodule

// File: tb/tb_ecc_wr_injector.sv
module tb_ecc_wr_injector;
  localparam int CW = 72;
  localparam logic [15:0] CMASK = 16'h0F7F;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, regWrEn, corrRptEn, wrStrobe;
  logic [15:0]   regWrData;
  logic [CW-1:0] wrCodeIn;
  logic [CW-1:0] memCodeOut;
  logic [15:0]   ctrlRd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] mCtrl;

  ecc_wr_injector #(.CODE_W(CW)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .corrRptEn(corrRptEn), .wrStrobe(wrStrobe), .wrCodeIn(wrCodeIn),
    .memCodeOut(memCodeOut), .ctrlRd(ctrlRd)
  );

  function automatic logic [CW-1:0] expMask(input logic [15:0] c, input logic s, input logic e);
    logic [CW-1:0] m = '0;
    int idx = int'(c[6:0]);
    logic dbl = c[10] | c[11];
    logic sgl = c[8] | c[9];
    if (s && e && idx < CW) begin
      if (dbl) begin
        m[idx] = 1'b1;
        m[(idx == CW-1) ? CW-2 : CW-1] = 1'b1;
      end else if (sgl) begin
        m[idx] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [CW-1:0] randCode();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare just after, then advance the model for the coming edge
  task automatic step(input logic we, input logic [15:0] wd, input logic s, input logic e,
                      input logic [CW-1:0] code, input string tag);
    logic [CW-1:0] m;
    @(negedge clk);
    regWrEn = we; regWrData = wd; wrStrobe = s; corrRptEn = e; wrCodeIn = code;
    #1;
    m = expMask(mCtrl, s, e);
    check(tag, "code", 128'(memCodeOut), 128'(code ^ m));
    check(tag, "ctrl", 128'(ctrlRd), 128'(mCtrl));
    if (we) mCtrl = wd & CMASK;
    else if (m != '0) begin
      if (mCtrl[10] | mCtrl[11]) mCtrl[11] = 1'b0;
      else mCtrl[9] = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c;
    void'($urandom(32'd20240611));
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; corrRptEn = 1'b1;
    wrStrobe = 1'b1; wrCodeIn = randCode();
    mCtrl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1", "reset ctrl", 128'(ctrlRd), 128'h0);
    check("R1", "reset pass", 128'(memCodeOut), 128'(wrCodeIn));

    // R3 continuous single at bit 5
    step(1'b1, 16'h0105, 1'b0, 1'b1, randCode(), "R1");
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b1, c, "R3");
    check("R3", "bit5", 128'(memCodeOut), 128'(c ^ (72'd1 << 5)));
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b1, c, "R6");
    check("R6", "cont stays", 128'(memCodeOut), 128'(c ^ (72'd1 << 5)));
    check("R6", "cont ctrl", 128'(ctrlRd), 128'h0105);
    // R2 no strobe
    c = randCode();
    step(1'b0, 16'h0, 1'b0, 1'b1, c, "R2");
    check("R2", "pass", 128'(memCodeOut), 128'(c));

    // R1 reserved bits
    step(1'b1, 16'hF0FF, 1'b0, 1'b1, randCode(), "R1");
    step(1'b0, 16'h0, 1'b0, 1'b1, randCode(), "R1");
    check("R1", "reserved", 128'(ctrlRd), 128'h007F);

    // R5 precedence: both armed, idx 3
    step(1'b1, 16'h0503, 1'b0, 1'b1, randCode(), "R5");
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b1, c, "R5");
    check("R5", "dbl wins", 128'(memCodeOut), 128'(c ^ (72'd1 << 3) ^ (72'd1 << 71)));

    // R4 one-shot double at top index, R6 self-clear
    step(1'b1, 16'h0847, 1'b0, 1'b1, randCode(), "R4");
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b1, c, "R4");
    check("R4", "alt pair", 128'(memCodeOut), 128'(c ^ (72'd1 << 71) ^ (72'd1 << 70)));
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b1, c, "R6");
    check("R6", "dbl cleared", 128'(ctrlRd), 128'h0047);
    check("R6", "no flip", 128'(memCodeOut), 128'(c));

    // R8 out of range index 100
    step(1'b1, 16'h0264, 1'b0, 1'b1, randCode(), "R8");
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b1, c, "R8");
    check("R8", "no flip", 128'(memCodeOut), 128'(c));
    step(1'b0, 16'h0, 1'b0, 1'b1, randCode(), "R8");
    check("R8", "armed", 128'(ctrlRd), 128'h0264);

    // R7 disabled then enabled
    step(1'b1, 16'h0209, 1'b0, 1'b1, randCode(), "R7");
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b0, c, "R7");
    check("R7", "no flip", 128'(memCodeOut), 128'(c));
    c = randCode();
    step(1'b0, 16'h0, 1'b1, 1'b1, c, "R7");
    check("R7", "still armed", 128'(memCodeOut), 128'(c ^ (72'd1 << 9)));
    step(1'b0, 16'h0, 1'b0, 1'b1, randCode(), "R6");
    check("R6", "sgl cleared", 128'(ctrlRd), 128'h0009);

    // R9 write coinciding with a corrupting write
    step(1'b1, 16'h020A, 1'b0, 1'b1, randCode(), "R9");
    c = randCode();
    step(1'b1, 16'h0211, 1'b1, 1'b1, c, "R9");
    check("R9", "old word used", 128'(memCodeOut), 128'(c ^ (72'd1 << 10)));
    step(1'b0, 16'h0, 1'b0, 1'b1, randCode(), "R9");
    check("R9", "new word kept", 128'(ctrlRd), 128'h0211);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] wd;
      logic we, s, e;
      we = ($urandom % 8) == 0;
      wd = 16'($urandom);
      if (($urandom % 4) != 0) wd[6:0] = 7'($urandom % CW);
      if (($urandom % 8) == 0) wd[6:0] = 7'(CW - 1);
      s = ($urandom % 3) != 0;
      e = ($urandom % 6) != 0;
      step(we, wd, s, e, randCode(), "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule